// File: doc/BRIEF.md
# Channel-Mask Broadcast Write Front End

This block sits at the command port of a four-channel device. It turns a byte stream into per-channel register writes. The stream arrives in pairs: a command byte, then a data byte. A pair whose command selects the channel mask loads a small enable register. Any other pair is a register write. That write goes to every channel whose mask bit is set. One write can therefore reach a single channel, any subset of channels, or all four channels at once (broadcast).

A separate read request returns the register of the one selected channel. When the mask names more than one channel, no channel is allowed onto the shared read path. The block returns zero and raises an error flag for that read.

Each channel target is modelled as an 8-bit register inside the block. Widths, the channel count and the mask-load code are parameters.

Top module: `mcb_bcast_front`

## Requirements
- R1: After reset, `chan_en` is 0, no `ch_wr` bit is set, `rd_valid` and `rd_err` are 0, `rd_data` is 0, and every channel register holds 0.
- R2: Bytes are accepted on cycles where `in_stb` is 1, and any number of idle cycles may sit between them. Accepted bytes alternate between command and data, starting with a command after reset. A data byte is never decoded as a command, even when its value equals the mask-load code.
- R3: A command byte of 0x4A or 0x4B loads the channel mask from the low four bits of the following data byte; bit 0 of the command is ignored. Mask bit 0 selects channel 1, bit 1 selects channel 2, bit 2 selects channel 3 and bit 3 selects channel 4. The new mask is visible on `chan_en` one cycle after the data byte. The upper four data bits are ignored.
- R4: Any other command code makes the following data byte a register write. One cycle after that data byte, `ch_wr` equals `chan_en` for exactly one cycle, and `ch_wdata` carries the data byte.
- R5: On the clock edge that follows a `ch_wr` pulse, each selected channel register takes `ch_wdata`. Unselected channel registers keep their value.
- R6: With mask 4'b1111 (broadcast), a single write updates all four channel registers to the same value.
- R7: A write issued while the mask is 0 produces no `ch_wr` pulse and changes no channel register.
- R8: A read request with exactly one mask bit set gives `rd_valid` = 1, `rd_err` = 0 and `rd_data` equal to that channel's register, one cycle after `rd_req`.
- R9: A read request with two or more mask bits set gives `rd_valid` = 1, `rd_data` = 0 and `rd_err` = 1, for one cycle. No channel drives the read path in that case.
- R10: A read request with mask 0 gives `rd_valid` = 1, `rd_data` = 0 and `rd_err` = 0. Whenever `rd_valid` is 0, `rd_data` and `rd_err` are also 0.
- R11: A mask-load pair never produces a `ch_wr` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_stb | input | 1 | Command/data byte strobe |
| in_byte | input | 8 | Command or data byte |
| rd_req | input | 1 | Read request for the selected channel |
| chan_en | output | 4 | Current channel mask |
| ch_wr | output | 4 | Per-channel write strobes |
| ch_wdata | output | 8 | Shared write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| rd_err | output | 1 | Read refused because several channels are selected |

## Verification
The hardest case to reach from the ports is a channel register that has to stay unchanged. Proving it requires steering the mask between writes and then reading each channel alone. The stimulus first loads different data into chosen subsets, including broadcast and an empty mask. It then steps the mask through every single channel and reads each one back. A data byte equal to the mask-load code is also sent, to show that framing does not slip. A behavioural reference model, advanced on every clock, predicts every output cycle by cycle.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
   typedef enum logic {PH_CMD = 1'b0, PH_DATA = 1'b1} phase_e;
   typedef enum logic {OP_WRITE = 1'b0, OP_MASK = 1'b1} op_e;
endpackage

// File: rtl/mcb_framer.sv
module mcb_framer
   import mcb_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] MASK_CODE = 'h4A,
   parameter logic [DATA_W-1:0] MASK_DONTCARE = 'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_stb,
   input  logic [DATA_W-1:0] in_byte,
   output logic [NUM_CH-1:0] en_mask,
   output logic [NUM_CH-1:0] wr_vec,
   output logic [DATA_W-1:0] wdata
);
   localparam logic [DATA_W-1:0] CARE = ~MASK_DONTCARE;

   if (DATA_W < NUM_CH) begin : g_bad_width
      $error("mcb_framer: DATA_W must cover NUM_CH mask bits");
   end

   phase_e            phase_q;
   op_e               op_q;
   logic [NUM_CH-1:0] en_q;
   logic [NUM_CH-1:0] wr_q;
   logic [DATA_W-1:0] wd_q;
   logic              is_mask_cmd;
   logic              data_beat;

   assign is_mask_cmd = ((in_byte ^ MASK_CODE) & CARE) == '0;
   assign data_beat   = in_stb && (phase_q == PH_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_CMD;
         op_q    <= OP_WRITE;
         en_q    <= '0;
         wr_q    <= '0;
         wd_q    <= '0;
      end else begin
         wr_q <= '0;
         if (in_stb) begin
            if (phase_q == PH_CMD) begin
               op_q    <= is_mask_cmd ? OP_MASK : OP_WRITE;
               phase_q <= PH_DATA;
            end else begin
               phase_q <= PH_CMD;
               if (op_q == OP_MASK) begin
                  en_q <= in_byte[NUM_CH-1:0];
               end else begin
                  wr_q <= en_q;
                  wd_q <= in_byte;
               end
            end
         end
      end
   end

   assign en_mask = en_q;
   assign wr_vec  = wr_q;
   assign wdata   = wd_q;

   assert_cmd_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_stb && phase_q == PH_CMD) |=> (phase_q == PH_DATA));

   assert_mask_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (data_beat && op_q == OP_MASK) |=> (wr_q == '0));

   assert_mask_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_beat && op_q == OP_MASK) |=> (en_q == $past(in_byte[NUM_CH-1:0])));
endmodule

// File: rtl/mcb_slot.sv
module mcb_slot #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_r <= '0;
      else if (wr) q_r <= wdata;
   end

   assign q = q_r;

   assert_slot_takes_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (q == $past(wdata)));

   assert_slot_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q));
endmodule

// File: rtl/mcb_rdport.sv
module mcb_rdport #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_req,
   input  logic [NUM_CH-1:0]        en_mask,
   input  logic [NUM_CH*DATA_W-1:0] slot_q,
   output logic                     rd_valid,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     rd_err
);
   localparam int CNT_W = $clog2(NUM_CH + 1);

   if (NUM_CH < 1) begin : g_bad_count
      $error("mcb_rdport: NUM_CH must be at least 1");
   end

   logic [CNT_W-1:0]  ones;
   logic              single;
   logic              multi;
   logic [NUM_CH-1:0] drive;
   logic [DATA_W-1:0] term [NUM_CH];
   logic [DATA_W-1:0] merged;

   always_comb begin
      ones = '0;
      for (int i = 0; i < NUM_CH; i++) ones = ones + CNT_W'(en_mask[i]);
   end

   assign single = (ones == CNT_W'(1));
   assign multi  = (ones > CNT_W'(1));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_term
      assign drive[i] = rd_req && single && en_mask[i];
      assign term[i]  = drive[i] ? slot_q[i*DATA_W +: DATA_W] : '0;
   end

   always_comb begin
      merged = '0;
      for (int i = 0; i < NUM_CH; i++) merged = merged | term[i];
   end

   logic              v_q;
   logic              e_q;
   logic [DATA_W-1:0] d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         e_q <= 1'b0;
         d_q <= '0;
      end else begin
         v_q <= rd_req;
         e_q <= rd_req && multi;
         d_q <= merged;
      end
   end

   assign rd_valid = v_q;
   assign rd_err   = e_q;
   assign rd_data  = d_q;

   assert_one_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drive));

   assert_err_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> (rd_valid && rd_data == '0));

   assert_valid_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0 && !rd_err));
endmodule

// File: rtl/mcb_bcast_front.sv
module mcb_bcast_front #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] MASK_CODE = 'h4A,
   parameter logic [DATA_W-1:0] MASK_DONTCARE = 'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_stb,
   input  logic [DATA_W-1:0] in_byte,
   input  logic              rd_req,
   output logic [NUM_CH-1:0] chan_en,
   output logic [NUM_CH-1:0] ch_wr,
   output logic [DATA_W-1:0] ch_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err
);
   localparam int FLAT_W = NUM_CH * DATA_W;

   logic [NUM_CH-1:0] en_w;
   logic [NUM_CH-1:0] wr_w;
   logic [DATA_W-1:0] wd_w;
   logic [FLAT_W-1:0] slot_flat;

   mcb_framer #(
      .NUM_CH(NUM_CH), .DATA_W(DATA_W),
      .MASK_CODE(MASK_CODE), .MASK_DONTCARE(MASK_DONTCARE)
   ) u_framer (
      .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_byte(in_byte),
      .en_mask(en_w), .wr_vec(wr_w), .wdata(wd_w)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
      mcb_slot #(.DATA_W(DATA_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .wr(wr_w[i]), .wdata(wd_w),
         .q(slot_flat[i*DATA_W +: DATA_W])
      );
   end

   mcb_rdport #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rdport (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .en_mask(en_w),
      .slot_q(slot_flat), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
   );

   assign chan_en  = en_w;
   assign ch_wr    = wr_w;
   assign ch_wdata = wd_w;

   assert_strobe_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_wr & ~chan_en) == '0);

   assert_strobe_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_wr != '0) |=> (ch_wr == '0));
endmodule

// File: tb/sim_mcb_bcast_front.sv
module sim_mcb_bcast_front;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_stb = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       rd_req = 1'b0;
   logic [3:0] chan_en;
   logic [3:0] ch_wr;
   logic [7:0] ch_wdata;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic       rd_err;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mcb_bcast_front u0 (
      .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_byte(in_byte), .rd_req(rd_req),
      .chan_en(chan_en), .ch_wr(ch_wr), .ch_wdata(ch_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
   );

   // behavioural reference model
   logic [3:0] m_en, m_wr;
   logic [7:0] m_wd, m_rd;
   logic [7:0] m_reg [4];
   bit         m_ph, m_op, m_rv, m_re;
   int         m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0; m_wr = 0; m_wd = 0; m_rd = 0;
         m_ph = 0; m_op = 0; m_rv = 0; m_re = 0;
         for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
      end else begin
         m_cnt = $countones(m_en);
         m_rv = rd_req;
         m_re = rd_req && (m_cnt > 1);
         m_rd = 8'h00;
         if (rd_req && m_cnt == 1)
            for (int i = 0; i < 4; i++) if (m_en[i]) m_rd = m_reg[i];
         for (int i = 0; i < 4; i++) if (m_wr[i]) m_reg[i] = m_wd;
         m_wr = 4'h0;
         if (in_stb) begin
            if (!m_ph) begin
               m_op = ((in_byte | 8'h01) == 8'h4B);
               m_ph = 1'b1;
            end else begin
               m_ph = 1'b0;
               if (m_op) m_en = in_byte[3:0];
               else begin
                  m_wr = m_en;
                  m_wd = in_byte;
               end
            end
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 chan_en model", chan_en, m_en);
         chk("R4 ch_wr model", ch_wr, m_wr);
         if (m_wr != 0) chk("R4 ch_wdata model", ch_wdata, m_wd);
         chk("R8 rd_valid model", rd_valid, m_rv);
         chk("R8 rd_data model", rd_data, m_rd);
         chk("R9 rd_err model", rd_err, m_re);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic send(logic [7:0] c, logic [7:0] d, int gap);
      in_stb = 1'b1; in_byte = c;
      @(negedge clk);
      in_stb = 1'b0;
      repeat (gap) @(negedge clk);
      in_stb = 1'b1; in_byte = d;
      @(negedge clk);
      in_stb = 1'b0;
   endtask

   task automatic rd(string tag, logic [7:0] exp_d, logic exp_e);
      @(negedge clk);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      chk({tag, " rd_valid"}, rd_valid, 1'b1);
      chk({tag, " rd_data"}, rd_data, exp_d);
      chk({tag, " rd_err"}, rd_err, exp_e);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 chan_en", chan_en, 4'h0);
      chk("R1 ch_wr", ch_wr, 4'h0);
      chk("R1 rd_valid/err", {rd_valid, rd_err}, 2'b00);
      chk("R1 rd_data", rd_data, 8'h00);
      rd("R1 empty-mask read", 8'h00, 1'b0);

      send(8'h4B, 8'hF5, 0);
      chk("R3 odd code, upper bits ignored", chan_en, 4'h5);
      send(8'h10, 8'h3C, 2);
      chk("R4 strobe equals mask", ch_wr, 4'h5);
      chk("R4 shared data", ch_wdata, 8'h3C);
      send(8'h4A, 8'h01, 0);
      rd("R5 channel 1 written", 8'h3C, 1'b0);
      send(8'h4A, 8'h04, 1);
      rd("R5 channel 3 written", 8'h3C, 1'b0);
      send(8'h4A, 8'h02, 0);
      rd("R5 channel 2 untouched", 8'h00, 1'b0);
      send(8'h4A, 8'h08, 0);
      rd("R5 channel 4 untouched", 8'h00, 1'b0);

      send(8'h20, 8'h4A, 1);
      chk("R2 data byte not a command", chan_en, 4'h8);
      rd("R2 data byte written", 8'h4A, 1'b0);

      send(8'h4A, 8'h0F, 0);
      chk("R11 mask load no strobe", ch_wr, 4'h0);
      send(8'h30, 8'hA7, 0);
      chk("R6 broadcast strobe", ch_wr, 4'hF);
      rd("R9 broadcast read refused", 8'h00, 1'b1);
      for (int i = 0; i < 4; i++) begin
         send(8'h4A, 8'h01 << i, 0);
         rd("R6 broadcast reached channel", 8'hA7, 1'b0);
      end

      send(8'h4A, 8'h00, 0);
      send(8'h40, 8'h11, 0);
      chk("R7 no strobe with empty mask", ch_wr, 4'h0);
      rd("R10 empty-mask read", 8'h00, 1'b0);
      for (int i = 0; i < 4; i++) begin
         send(8'h4A, 8'h01 << i, 0);
         rd("R7 discarded write", 8'hA7, 1'b0);
      end

      send(8'h4A, 8'h06, 0);
      rd("R9 two-channel read refused", 8'h00, 1'b1);
      send(8'h55, 8'h5A, 0);
      send(8'h4A, 8'h01, 0); rd("R5 subset ch1 kept", 8'hA7, 1'b0);
      send(8'h4A, 8'h02, 0); rd("R5 subset ch2", 8'h5A, 1'b0);
      send(8'h4A, 8'h04, 0); rd("R5 subset ch3", 8'h5A, 1'b0);
      send(8'h4A, 8'h08, 0); rd("R8 subset ch4 kept", 8'hA7, 1'b0);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule